// File: doc/BRIEF.md
# Front-Panel Indicator Register Block

This block sits on a simple synchronous register port and drives the indicators on a front panel. It has two bicolour status lamps, one seven-segment digit with a decimal point, and a 16-position rotary selector. Each lamp has a small configuration register. Two bits of that register pick the colour, and two bits pick either a steady output or one of three blink rates. The digit register drives each segment directly. The selector position is synchronised and debounced, and it can then be read at its own offset.

All blink timing comes from one free-running prescaler. The prescaler produces a tick every quarter second. A 3-bit phase counter advances on each tick. Its bit 0, bit 1 and bit 2 are square waves at 2 Hz, 1 Hz and 0.5 Hz, so the three rates always stay phase aligned. A blinking lamp shows its colour while its phase bit is 0 and goes dark while the bit is 1.

The register port carries control traffic only, so it has no valid/ready handshake. A write takes effect on the clock edge at which `bus_we` is high. `bus_rdata` is a registered copy of the register addressed in the previous cycle. Reset is synchronous and active high.

Top module: `panel_ind_ctrl`

## Requirements
- R1: Lamp register bits 1:0 select the colour. 00 lights nothing, 01 lights green only, 10 lights red only, and 11 lights both red and green.
- R2: Lamp register bits 3:2 select the blink mode. 00 is steady. 01 follows phase bit 2 (0.5 Hz), 10 follows phase bit 1 (1 Hz), and 11 follows phase bit 0 (2 Hz). The phase is floor(k / QUARTER_CYCLES) mod 8 after k clock edges out of reset. The lamp is lit when the selected phase bit is 0.
- R3: Lamp 0 lives at offset 0 and lamp 1 at offset 1. A write to one lamp leaves the other lamp's register and outputs unchanged.
- R4: Lamp registers keep only bits 3:0. Bits 7:4 ignore writes and read back as zero, and bits 3:0 read back as written.
- R5: Offset 2 is the digit register. Bit i (i = 0..6) drives `seg_out[i]`, which is segments A to G, and bit 7 drives `seg_dp`. All 8 bits read back as written.
- R6: A read of offset 3 returns the debounced selector position in bits 3:0 and zeros in bits 7:4. Writes to offset 3 change nothing.
- R7: The selector input passes through two synchronising flops. The readable position updates only after the synchronised value has stayed the same for DEBOUNCE_CYCLES consecutive cycles. A change that lasts fewer cycles is ignored.
- R8: Reset clears both lamp registers, the digit register, the selector position and the prescaler, so every indicator is dark.
- R9: `bus_rdata` shows the register addressed at clock edge n from edge n onward, which is one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rot_sw | input | 4 | Raw rotary selector position |
| led_red | output | 2 | Red element for each lamp |
| led_grn | output | 2 | Green element for each lamp |
| seg_out | output | 7 | Segments A to G |
| seg_dp | output | 1 | Decimal point |

## Verification
The bench runs every one of the 16 lamp codes on each lamp and compares the outputs against an arithmetic phase model on every cycle. A wrong stage tap, an inverted on-half or an off-by-one prescaler would show up as a mismatch within a few quarter periods. Lamp writes carry junk in bits 7:4 and the bench checks that those bits read back as zero. The bench also confirms that a write to one lamp leaves the other lamp dark, which would catch a crossed decode. All 256 digit patterns are swept, and the sweep would expose segment reordering. On the selector side, the bench checks that a glitch shorter than the debounce window is ignored, that a real change is not visible too early, and that writes to the read-only offset have no effect.

// File: rtl/panel_pkg.sv
package panel_pkg;
  localparam int REG_W = 8;
  localparam int OFS_W = 2;
  localparam logic [OFS_W-1:0] OFS_LAMP0 = 2'd0;
  localparam logic [OFS_W-1:0] OFS_LAMP1 = 2'd1;
  localparam logic [OFS_W-1:0] OFS_DIGIT = 2'd2;
  localparam logic [OFS_W-1:0] OFS_ROT   = 2'd3;

  typedef enum logic [1:0] {
    BLK_STEADY = 2'b00,
    BLK_SLOW   = 2'b01,
    BLK_MID    = 2'b10,
    BLK_FAST   = 2'b11
  } blink_e;

  typedef struct packed {
    blink_e     blink;
    logic [1:0] colour;
  } lamp_cfg_t;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int QUARTER_CYCLES = 25_000_000,
  parameter int PHASE_W        = 3
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PHASE_W-1:0] phase
);
  localparam int CW = $clog2(QUARTER_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);

  logic [CW-1:0] div_q;
  logic          tick;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      phase <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/rot_debounce.sv
module rot_debounce #(
  parameter int W               = 4,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] value
);
  localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic [W-1:0]  sync1, sync2, cand;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      cand  <= '0;
      run   <= '0;
      value <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      if (sync2 != cand) begin
        cand <= sync2;
        run  <= '0;
      end else if (run != LAST) begin
        run <= run + 1'b1;
      end else begin
        value <= cand;
      end
    end
  end
endmodule

// File: rtl/lamp_channel.sv
module lamp_channel
  import panel_pkg::*;
(
  input  lamp_cfg_t  cfg,
  input  logic [2:0] phase,
  output logic       red,
  output logic       grn
);
  logic lit;

  always_comb begin
    unique case (cfg.blink)
      BLK_STEADY: lit = 1'b1;
      BLK_SLOW:   lit = ~phase[2];
      BLK_MID:    lit = ~phase[1];
      BLK_FAST:   lit = ~phase[0];
    endcase
  end

  assign red = cfg.colour[1] & lit;
  assign grn = cfg.colour[0] & lit;
endmodule

// File: rtl/panel_ind_ctrl.sv
module panel_ind_ctrl
  import panel_pkg::*;
#(
  parameter int QUARTER_CYCLES  = 25_000_000,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int N_LAMPS         = 2,
  parameter int ROT_W           = 4,
  parameter int SEG_N           = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [ROT_W-1:0] rot_sw,
  output logic [N_LAMPS-1:0] led_red,
  output logic [N_LAMPS-1:0] led_grn,
  output logic [SEG_N-1:0] seg_out,
  output logic             seg_dp
);
  localparam int CFG_W = $bits(lamp_cfg_t);

  lamp_cfg_t        lamp_q [N_LAMPS];
  logic [REG_W-1:0] digit_q;
  logic [ROT_W-1:0] rot_val;
  logic [2:0]       phase;
  logic [REG_W-1:0] rd_mux;

  blink_prescaler #(.QUARTER_CYCLES(QUARTER_CYCLES), .PHASE_W(3)) u_presc (
    .clk(clk), .rst(rst), .phase(phase)
  );

  rot_debounce #(.W(ROT_W), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_rot (
    .clk(clk), .rst(rst), .raw(rot_sw), .value(rot_val)
  );

  for (genvar i = 0; i < N_LAMPS; i++) begin : g_lamp
    always_ff @(posedge clk) begin
      if (rst) lamp_q[i] <= '0;
      else if (bus_we && bus_addr == OFS_W'(i)) lamp_q[i] <= lamp_cfg_t'(bus_wdata[CFG_W-1:0]);
    end
    lamp_channel u_ch (
      .cfg(lamp_q[i]), .phase(phase), .red(led_red[i]), .grn(led_grn[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) digit_q <= '0;
    else if (bus_we && bus_addr == OFS_DIGIT) digit_q <= bus_wdata;
  end

  assign seg_out = digit_q[SEG_N-1:0];
  assign seg_dp  = digit_q[REG_W-1];

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_LAMP0: rd_mux[CFG_W-1:0] = lamp_q[0];
      OFS_LAMP1: rd_mux[CFG_W-1:0] = lamp_q[1];
      OFS_DIGIT: rd_mux = digit_q;
      OFS_ROT:   rd_mux[ROT_W-1:0] = rot_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/panel_ind_chk.sv
module panel_ind_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [1:0] led_red,
  input logic [1:0] led_grn,
  input logic [6:0] seg_out,
  input logic       seg_dp,
  input logic [3:0] cfg0,
  input logic [3:0] cfg1
);
  assert_off_is_dark_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg0[1:0] == 2'b00) |-> (!led_red[0] && !led_grn[0]));

  assert_lamp_isolated_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd0) |=> $stable(cfg1));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != 2'd2) |=> (bus_rdata[7:4] == 4'h0));

  assert_digit_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd2) |=> ({seg_dp, seg_out} == $past(bus_wdata)));

  assert_rot_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd3) |=> ($stable(cfg0) && $stable(cfg1) && $stable({seg_dp, seg_out})));

  assert_reset_dark_R8: assert property (@(posedge clk)
    rst |=> (led_red == 2'b00 && led_grn == 2'b00 && seg_out == 7'h00 && !seg_dp));
endmodule

bind panel_ind_ctrl panel_ind_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_red(led_red),
  .led_grn(led_grn), .seg_out(seg_out), .seg_dp(seg_dp),
  .cfg0(lamp_q[0]), .cfg1(lamp_q[1])
);

// File: tb/panel_ind_ctrl_bench.sv
module panel_ind_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q   = 4;
  localparam int DEB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] rot_sw = 4'h0;
  logic [1:0] led_red, led_grn;
  logic [6:0] seg_out;
  logic       seg_dp;

  int errors = 0;
  int checks = 0;
  int ecount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (!rst) ecount <= ecount + 1;

  panel_ind_ctrl #(.QUARTER_CYCLES(Q), .DEBOUNCE_CYCLES(DEB)) u_panel_ind_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rot_sw(rot_sw),
    .led_red(led_red), .led_grn(led_grn), .seg_out(seg_out), .seg_dp(seg_dp)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic lit_exp(input logic [1:0] blk);
    int ph;
    ph = (ecount / Q) % 8;
    case (blk)
      2'b00: return 1'b1;
      2'b01: return ((ph >> 2) & 1) == 0;
      2'b10: return ((ph >> 1) & 1) == 0;
      default: return (ph & 1) == 0;
    endcase
  endfunction

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 red", led_red, 0);
    check("R8 grn", led_grn, 0);
    check("R8 seg", {seg_dp, seg_out}, 0);
    rst = 1'b0;
    rd(2'd3, d); check("R8 rot", d, 0);
    rd(2'd0, d); check("R8 lamp0", d, 0);

    // R1 R2 R3 R4: every code on each lamp, junk in bits 7:4
    for (int ch = 0; ch < 2; ch++) begin
      for (int code = 0; code < 16; code++) begin
        wr(2'(ch), {4'(~code), 4'(code)});
        rd(2'(ch), d);
        check("R4 readback", d, code);
        for (int c = 0; c < 40; c++) begin
          logic l;
          @(negedge clk);
          l = lit_exp(2'(code >> 2));
          check("R1 R2 red", led_red[ch], int'(code[1] & l));
          check("R1 R2 grn", led_grn[ch], int'(code[0] & l));
          check("R3 other lamp dark", {led_red[1-ch], led_grn[1-ch]}, 0);
        end
        wr(2'(ch), 8'h00);
      end
    end

    // R9: read latency, value present one edge after address
    wr(2'd1, 8'h07);
    @(negedge clk); bus_addr = 2'd1;
    @(negedge clk); check("R9 latency", bus_rdata, 8'h07);
    wr(2'd1, 8'h00);

    // R5: full digit sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v));
      check("R5 segs", {seg_dp, seg_out}, v);
      rd(2'd2, d);
      check("R5 readback", d, v);
    end

    // R6 R7: selector positions
    for (int p = 0; p < 16; p++) begin
      rot_sw = 4'(p);
      repeat (DEB + 6) @(negedge clk);
      rd(2'd3, d);
      check("R6 R7 rot", d, p);
    end
    rot_sw = 4'h5;
    repeat (DEB + 6) @(negedge clk);
    rot_sw = 4'hA;
    repeat (DEB - 2) @(negedge clk);
    rot_sw = 4'h5;
    repeat (3 * DEB) @(negedge clk);
    rd(2'd3, d); check("R7 glitch ignored", d, 5);
    rot_sw = 4'h9;
    rd(2'd3, d); check("R7 not early", d, 5);
    repeat (DEB + 6) @(negedge clk);
    rd(2'd3, d); check("R7 settled", d, 9);

    // R6: write to selector offset ignored
    wr(2'd2, 8'h5A);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); check("R6 rot unchanged", d, 9);
    check("R6 digit unchanged", {seg_dp, seg_out}, 8'h5A);
    rd(2'd0, d); check("R6 lamp0 unchanged", d, 0);
    rd(2'd1, d); check("R6 lamp1 unchanged", d, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule